// File: doc/BRIEF.md
# Write-Drain Mode Command Gate

This block sits beside a DRAM command scheduler. Each cycle it judges one candidate command and decides whether the command may go out. Two drain phases govern that decision. When writeback mode begins, a count of reads still owed is loaded, and until that count reaches zero no WRITE may issue. When writeback mode ends, a count of writes still owed is loaded, and until that count reaches zero no READ may issue. When neither phase blocks the command, the decision defers to the timing-ready flag for the command's type. Those flags come from an external timing checker.

When the scheduler issues an allowed command that carries the drain tag, the matching counter steps down. Any other issued WRITE produces a write-served strobe that carries its channel ID. Inside writeback mode the block also keeps separate counts of issued reads and issued writes for statistics. An invalid command type is refused and flagged. A decrement of a counter that is already empty is flagged and does not wrap.

Top module: `drain_cmd_gate`

## Requirements
- R1: While wbMode is 1 and rdDrainCnt is nonzero, a valid WRITE (cmdType 3) sees allow = 0.
- R2: While wbMode is 0 and wrDrainCnt is nonzero, a valid READ (cmdType 2) sees allow = 0.
- R3: When no drain rule blocks it, allow for a valid command equals the ready flag of its type (cmdType 0 ACTIVATE uses actReady, 1 PRECHARGE uses preReady, 2 READ uses rdReady, 3 WRITE uses wrReady). allow is 0 whenever cmdValid is 0. allow and badCmd are combinational.
- R4: A command is issued when cmdValid, cmdIssue and allow are all 1. An issued drain-tagged READ in writeback mode lowers rdDrainCnt by one at the next clock edge. A drain-tagged READ issued outside writeback mode leaves the count unchanged.
- R5: An issued drain-tagged WRITE outside writeback mode lowers wrDrainCnt by one at the next clock edge.
- R6: Every other issued WRITE (drain tag 0, or wbMode 1) sets wrServed high for exactly the following cycle, with wrServedChan holding the command's cmdChan.
- R7: In writeback mode, wbRdIssues and wbWrIssues count issued READs and issued WRITEs separately. On the first cycle of each writeback mode (wbMode 1 after a cycle at 0, or the first cycle after reset), both counts restart from that cycle's issues. Outside writeback mode they hold.
- R8: A valid command whose cmdType is 4 to 7 gives allow = 0 and badCmd = 1.
- R9: A counted drain decrement that finds its counter at zero leaves the counter at zero and sets underflowErr. underflowErr stays set until reset.
- R10: A load (rdLoad or wrLoad) writes its value at the next edge and overrides a same-cycle decrement of that counter. The overridden decrement raises no error.
- R11: After reset, both drain counts, both statistics counts, wrServed and underflowErr are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Candidate command present |
| cmdType | input | 3 | 0 ACTIVATE, 1 PRECHARGE, 2 READ, 3 WRITE, 4-7 invalid |
| cmdDrain | input | 1 | Command belongs to a drain phase |
| cmdChan | input | CHAN_W | Channel ID of the command |
| cmdIssue | input | 1 | Scheduler takes the command this cycle |
| wbMode | input | 1 | Writeback mode active |
| rdLoad | input | 1 | Load reads-to-drain count |
| rdLoadVal | input | CNT_W | Value for rdLoad |
| wrLoad | input | 1 | Load writes-to-drain count |
| wrLoadVal | input | CNT_W | Value for wrLoad |
| actReady | input | 1 | Timing allows ACTIVATE |
| preReady | input | 1 | Timing allows PRECHARGE |
| rdReady | input | 1 | Timing allows READ |
| wrReady | input | 1 | Timing allows WRITE |
| allow | output | 1 | Candidate may issue |
| badCmd | output | 1 | Candidate has an invalid type |
| rdDrainCnt | output | CNT_W | Reads still to drain |
| wrDrainCnt | output | CNT_W | Writes still to drain |
| underflowErr | output | 1 | Sticky empty-counter decrement flag |
| wrServed | output | 1 | Non-drain write served strobe |
| wrServedChan | output | CHAN_W | Channel of the served write |
| wbRdIssues | output | STAT_W | READs issued in current writeback mode |
| wbWrIssues | output | STAT_W | WRITEs issued in current writeback mode |

## Verification
A wrong drain count shows up at rdDrainCnt or wrDrainCnt at the first clock edge after the faulty update. It then corrupts allow for the opposite command direction on every following cycle until the count is reloaded. A wrong decision on empty counters shows either as a wrapped count one edge later or as a missing sticky underflowErr. Errors in strobe routing show on wrServed and the statistics counts one cycle after the issue. A random mix of modes, loads and tagged commands checks every cycle against a bench model, so any of these faults is seen within one cycle of where it arises.

// File: rtl/drain_gate_pkg.sv
package drain_gate_pkg;
  localparam logic [2:0] CMD_ACT = 3'd0;
  localparam logic [2:0] CMD_PRE = 3'd1;
  localparam logic [2:0] CMD_RD  = 3'd2;
  localparam logic [2:0] CMD_WR  = 3'd3;

  // Strobes from control to datapath, one cycle's worth of updates
  typedef struct packed {
    logic decRd;
    logic decWr;
    logic underRd;
    logic underWr;
    logic servWr;
    logic statRd;
    logic statWr;
    logic clrStat;
  } gateStrobe_t;
endpackage

// File: rtl/drain_gate_ctrl.sv
module drain_gate_ctrl
  import drain_gate_pkg::*;
(
  input  logic        cmdValid,
  input  logic [2:0]  cmdType,
  input  logic        cmdDrain,
  input  logic        cmdIssue,
  input  logic        wbMode,
  input  logic        wbPrev,
  input  logic        rdLoad,
  input  logic        wrLoad,
  input  logic        rdPending,
  input  logic        wrPending,
  input  logic        actReady,
  input  logic        preReady,
  input  logic        rdReady,
  input  logic        wrReady,
  output logic        allow,
  output logic        badCmd,
  output gateStrobe_t strobe
);
  logic isRd, isWr, validType, drainBlock, readyOk, fire, drainRd, drainWr;

  always_comb begin
    validType = (cmdType[2] == 1'b0);
    isRd      = (cmdType == CMD_RD);
    isWr      = (cmdType == CMD_WR);
    unique case (cmdType)
      CMD_ACT: readyOk = actReady;
      CMD_PRE: readyOk = preReady;
      CMD_RD:  readyOk = rdReady;
      CMD_WR:  readyOk = wrReady;
      default: readyOk = 1'b0;
    endcase
    // read phase blocks writes, write phase blocks reads
    drainBlock = (wbMode && rdPending && isWr) || (!wbMode && wrPending && isRd);
    allow  = cmdValid && validType && !drainBlock && readyOk;
    badCmd = cmdValid && !validType;
    fire    = allow && cmdIssue;
    drainRd = fire && isRd && wbMode && cmdDrain;
    drainWr = fire && isWr && !wbMode && cmdDrain;

    strobe.decRd   = drainRd && !rdLoad && rdPending;
    strobe.underRd = drainRd && !rdLoad && !rdPending;
    strobe.decWr   = drainWr && !wrLoad && wrPending;
    strobe.underWr = drainWr && !wrLoad && !wrPending;
    strobe.servWr  = fire && isWr && !drainWr;
    strobe.statRd  = fire && isRd && wbMode;
    strobe.statWr  = fire && isWr && wbMode;
    strobe.clrStat = wbMode && !wbPrev;
  end
endmodule

// File: rtl/drain_gate_dp.sv
module drain_gate_dp
  import drain_gate_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int CHAN_W = 2,
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  gateStrobe_t       strobe,
  input  logic              wbMode,
  input  logic [CHAN_W-1:0] cmdChan,
  input  logic              rdLoad,
  input  logic [CNT_W-1:0]  rdLoadVal,
  input  logic              wrLoad,
  input  logic [CNT_W-1:0]  wrLoadVal,
  output logic [CNT_W-1:0]  rdCnt,
  output logic [CNT_W-1:0]  wrCnt,
  output logic              rdPending,
  output logic              wrPending,
  output logic              wbPrev,
  output logic              underErr,
  output logic              served,
  output logic [CHAN_W-1:0] servedChan,
  output logic [STAT_W-1:0] statRdCnt,
  output logic [STAT_W-1:0] statWrCnt
);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
  localparam logic [STAT_W-1:0] STAT_ONE = STAT_W'(1);

  assign rdPending = (rdCnt != '0);
  assign wrPending = (wrCnt != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdCnt      <= '0;
      wrCnt      <= '0;
      wbPrev     <= 1'b0;
      underErr   <= 1'b0;
      served     <= 1'b0;
      servedChan <= '0;
      statRdCnt  <= '0;
      statWrCnt  <= '0;
    end else begin
      if (rdLoad)            rdCnt <= rdLoadVal;
      else if (strobe.decRd) rdCnt <= rdCnt - CNT_ONE;
      if (wrLoad)            wrCnt <= wrLoadVal;
      else if (strobe.decWr) wrCnt <= wrCnt - CNT_ONE;
      wbPrev   <= wbMode;
      underErr <= underErr || strobe.underRd || strobe.underWr;
      served   <= strobe.servWr;
      if (strobe.servWr) servedChan <= cmdChan;
      if (strobe.clrStat) begin
        statRdCnt <= strobe.statRd ? STAT_ONE : '0;
        statWrCnt <= strobe.statWr ? STAT_ONE : '0;
      end else begin
        if (strobe.statRd) statRdCnt <= statRdCnt + STAT_ONE;
        if (strobe.statWr) statWrCnt <= statWrCnt + STAT_ONE;
      end
    end
  end
endmodule

// File: rtl/drain_cmd_gate.sv
module drain_cmd_gate
  import drain_gate_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int CHAN_W = 2,
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdType,
  input  logic              cmdDrain,
  input  logic [CHAN_W-1:0] cmdChan,
  input  logic              cmdIssue,
  input  logic              wbMode,
  input  logic              rdLoad,
  input  logic [CNT_W-1:0]  rdLoadVal,
  input  logic              wrLoad,
  input  logic [CNT_W-1:0]  wrLoadVal,
  input  logic              actReady,
  input  logic              preReady,
  input  logic              rdReady,
  input  logic              wrReady,
  output logic              allow,
  output logic              badCmd,
  output logic [CNT_W-1:0]  rdDrainCnt,
  output logic [CNT_W-1:0]  wrDrainCnt,
  output logic              underflowErr,
  output logic              wrServed,
  output logic [CHAN_W-1:0] wrServedChan,
  output logic [STAT_W-1:0] wbRdIssues,
  output logic [STAT_W-1:0] wbWrIssues
);
  gateStrobe_t strobe;
  logic rdPending, wrPending, wbPrev;

  drain_gate_ctrl uCtrl (
    .cmdValid (cmdValid), .cmdType (cmdType), .cmdDrain (cmdDrain),
    .cmdIssue (cmdIssue), .wbMode (wbMode), .wbPrev (wbPrev),
    .rdLoad (rdLoad), .wrLoad (wrLoad),
    .rdPending (rdPending), .wrPending (wrPending),
    .actReady (actReady), .preReady (preReady),
    .rdReady (rdReady), .wrReady (wrReady),
    .allow (allow), .badCmd (badCmd), .strobe (strobe)
  );

  drain_gate_dp #(.CNT_W(CNT_W), .CHAN_W(CHAN_W), .STAT_W(STAT_W)) uDp (
    .clk (clk), .rstN (rstN), .strobe (strobe), .wbMode (wbMode),
    .cmdChan (cmdChan), .rdLoad (rdLoad), .rdLoadVal (rdLoadVal),
    .wrLoad (wrLoad), .wrLoadVal (wrLoadVal),
    .rdCnt (rdDrainCnt), .wrCnt (wrDrainCnt),
    .rdPending (rdPending), .wrPending (wrPending), .wbPrev (wbPrev),
    .underErr (underflowErr), .served (wrServed), .servedChan (wrServedChan),
    .statRdCnt (wbRdIssues), .statWrCnt (wbWrIssues)
  );
endmodule

// File: rtl/drain_gate_chk.sv
module drain_gate_chk #(
  parameter int CNT_W  = 6,
  parameter int CHAN_W = 2,
  parameter int STAT_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic [2:0]        cmdType,
  input logic              cmdDrain,
  input logic [CHAN_W-1:0] cmdChan,
  input logic              cmdIssue,
  input logic              wbMode,
  input logic              rdLoad,
  input logic [CNT_W-1:0]  rdLoadVal,
  input logic              wrLoad,
  input logic [CNT_W-1:0]  wrLoadVal,
  input logic              allow,
  input logic              badCmd,
  input logic [CNT_W-1:0]  rdDrainCnt,
  input logic [CNT_W-1:0]  wrDrainCnt,
  input logic              underflowErr,
  input logic              wrServed,
  input logic [CHAN_W-1:0] wrServedChan
);
  a_r1_no_write_in_read_drain: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdType == 3'd3 && wbMode && rdDrainCnt != '0) |-> !allow);

  a_r2_no_read_in_write_drain: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdType == 3'd2 && !wbMode && wrDrainCnt != '0) |-> !allow);

  a_r4_read_drain_step: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdIssue && allow && cmdType == 3'd2 && wbMode && cmdDrain
     && !rdLoad && rdDrainCnt != '0)
    |=> (rdDrainCnt == $past(rdDrainCnt) - CNT_W'(1)));

  a_r5_write_drain_step: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdIssue && allow && cmdType == 3'd3 && !wbMode && cmdDrain
     && !wrLoad && wrDrainCnt != '0)
    |=> (wrDrainCnt == $past(wrDrainCnt) - CNT_W'(1)));

  a_r6_served_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdIssue && allow && cmdType == 3'd3 && (wbMode || !cmdDrain))
    |=> (wrServed && wrServedChan == $past(cmdChan)));

  a_r8_bad_type: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdType[2]) |-> (!allow && badCmd));

  a_r9_underflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    underflowErr |=> underflowErr);

  a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (rdDrainCnt == '0 && !rdLoad) |=> (rdDrainCnt == '0));

  a_r10_load_wins: assert property (@(posedge clk) disable iff (!rstN)
    rdLoad |=> (rdDrainCnt == $past(rdLoadVal)));
endmodule

bind drain_cmd_gate drain_gate_chk #(.CNT_W(CNT_W), .CHAN_W(CHAN_W), .STAT_W(STAT_W)) uChk (.*);

// File: tb/tb_drain_cmd_gate.sv
`timescale 1ns/1ps
module tb_drain_cmd_gate;
  localparam int CNT_W = 6, CHAN_W = 2, STAT_W = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic cmdValid = 0, cmdDrain = 0, cmdIssue = 0, wbMode = 0, rdLoad = 0, wrLoad = 0;
  logic [2:0] cmdType = 0;
  logic [CHAN_W-1:0] cmdChan = 0;
  logic [CNT_W-1:0] rdLoadVal = 0, wrLoadVal = 0;
  logic actReady = 0, preReady = 0, rdReady = 0, wrReady = 0;
  logic allow, badCmd, underflowErr, wrServed;
  logic [CNT_W-1:0] rdDrainCnt, wrDrainCnt;
  logic [CHAN_W-1:0] wrServedChan;
  logic [STAT_W-1:0] wbRdIssues, wbWrIssues;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model state
  logic [CNT_W-1:0] mRd = 0, mWr = 0;
  logic mUnder = 0, mServ = 0, mWbPrev = 0;
  logic [CHAN_W-1:0] mChan = 0;
  logic [STAT_W-1:0] mSRd = 0, mSWr = 0;

  always #10 clk = ~clk;

  drain_cmd_gate #(.CNT_W(CNT_W), .CHAN_W(CHAN_W), .STAT_W(STAT_W)) dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic readyFor(input logic [2:0] t, input logic [3:0] rdy);
    if (t[2]) return 1'b0;
    return rdy[t[1:0]];
  endfunction

  function automatic string allowTag(input logic [2:0] t, input logic wb);
    if (t[2]) return "R8";
    if (t == 3'd3 && wb && mRd != 0) return "R1";
    if (t == 3'd2 && !wb && mWr != 0) return "R2";
    return "R3";
  endfunction

  function automatic logic expAllow(input logic v, input logic [2:0] t, input logic wb,
                                    input logic [3:0] rdy);
    if (!v || t[2]) return 1'b0;
    if (t == 3'd3 && wb && mRd != 0) return 1'b0;
    if (t == 3'd2 && !wb && mWr != 0) return 1'b0;
    return readyFor(t, rdy);
  endfunction

  // one cycle: drive at negedge, check comb, advance model, check registers
  task automatic step(input logic v, input logic [2:0] t, input logic d, input logic iss,
                      input logic wb, input logic rl, input logic [CNT_W-1:0] rv,
                      input logic wl, input logic [CNT_W-1:0] wv,
                      input logic [3:0] rdy, input logic [CHAN_W-1:0] ch);
    logic ea, fire, isRd, isWr;
    logic [CNT_W-1:0] nRd, nWr;
    logic [STAT_W-1:0] nSRd, nSWr;
    logic nUnder, nServ;
    logic [CHAN_W-1:0] nChan;
    cmdValid = v; cmdType = t; cmdDrain = d; cmdIssue = iss; wbMode = wb;
    rdLoad = rl; rdLoadVal = rv; wrLoad = wl; wrLoadVal = wv;
    {wrReady, rdReady, preReady, actReady} = rdy; cmdChan = ch;
    #1;
    ea = expAllow(v, t, wb, rdy);
    chk(allowTag(t, wb), {31'd0, allow}, {31'd0, ea});
    chk("R8 badCmd", {31'd0, badCmd}, {31'd0, v && t[2]});
    fire = ea && iss; isRd = (t == 3'd2); isWr = (t == 3'd3);
    nRd = mRd; nWr = mWr; nUnder = mUnder; nChan = mChan;
    if (rl) nRd = rv;
    else if (fire && isRd && wb && d) begin
      if (mRd == 0) nUnder = 1; else nRd = mRd - 1;
    end
    if (wl) nWr = wv;
    else if (fire && isWr && !wb && d) begin
      if (mWr == 0) nUnder = 1; else nWr = mWr - 1;
    end
    nServ = fire && isWr && !(!wb && d);
    if (nServ) nChan = ch;
    nSRd = mSRd; nSWr = mSWr;
    if (wb && !mWbPrev) begin
      nSRd = (fire && isRd) ? 1 : 0;
      nSWr = (fire && isWr) ? 1 : 0;
    end else if (wb) begin
      if (fire && isRd) nSRd = mSRd + 1;
      if (fire && isWr) nSWr = mSWr + 1;
    end
    @(posedge clk);
    @(negedge clk);
    mRd = nRd; mWr = nWr; mUnder = nUnder; mServ = nServ; mChan = nChan;
    mSRd = nSRd; mSWr = nSWr; mWbPrev = wb;
    chk("R4 rdDrainCnt", 32'(rdDrainCnt), 32'(mRd));
    chk("R5 wrDrainCnt", 32'(wrDrainCnt), 32'(mWr));
    chk("R9 underflowErr", {31'd0, underflowErr}, {31'd0, mUnder});
    chk("R6 wrServed", {31'd0, wrServed}, {31'd0, mServ});
    if (mServ) chk("R6 wrServedChan", 32'(wrServedChan), 32'(mChan));
    chk("R7 wbRdIssues", 32'(wbRdIssues), 32'(mSRd));
    chk("R7 wbWrIssues", 32'(wbWrIssues), 32'(mSWr));
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R11 reset values
    chk("R11 rdDrainCnt", 32'(rdDrainCnt), 0);
    chk("R11 wrDrainCnt", 32'(wrDrainCnt), 0);
    chk("R11 underflowErr", {31'd0, underflowErr}, 0);
    chk("R11 wrServed", {31'd0, wrServed}, 0);
    chk("R11 stats", 32'({wbRdIssues, wbWrIssues}), 0);
    rstN = 1;

    // enter writeback mode, load two reads to drain
    step(0, 3'd0, 0, 0, 1, 1, 6'd2, 0, 6'd0, 4'hF, 0);
    chk("R10 load", 32'(rdDrainCnt), 2);
    // R1 write refused despite ready; R3 read allowed by ready flag
    step(1, 3'd3, 0, 1, 1, 0, 0, 0, 0, 4'hF, 1);
    step(1, 3'd2, 0, 0, 1, 0, 0, 0, 0, 4'b1011, 0); // R3 rdReady low
    step(1, 3'd2, 1, 1, 1, 0, 0, 0, 0, 4'hF, 0);    // R4 to 1
    step(1, 3'd2, 1, 1, 1, 0, 0, 0, 0, 4'hF, 0);    // R4 to 0
    chk("R4 drained", 32'(rdDrainCnt), 0);
    step(1, 3'd3, 0, 1, 1, 0, 0, 0, 0, 4'hF, 2'd3); // R6 write in wb
    chk("R6 chan", 32'(wrServedChan), 3);
    chk("R7 reads in wb", 32'(wbRdIssues), 2);
    // R10: drain read at zero with same-cycle load: no error
    step(1, 3'd2, 1, 1, 1, 1, 6'd5, 0, 0, 4'hF, 0);
    chk("R10 load over decrement", 32'(rdDrainCnt), 5);
    chk("R10 no error", {31'd0, underflowErr}, 0);
    step(0, 3'd0, 0, 0, 1, 1, 6'd0, 0, 0, 4'hF, 0);
    // R9 underflow on empty counter
    step(1, 3'd2, 1, 1, 1, 0, 0, 0, 0, 4'hF, 0);
    chk("R9 flag", {31'd0, underflowErr}, 1);
    chk("R9 no wrap", 32'(rdDrainCnt), 0);
    // leave wb mode, write drain of one
    step(0, 3'd0, 0, 0, 0, 0, 0, 1, 6'd1, 4'hF, 0);
    step(1, 3'd2, 0, 1, 0, 0, 0, 0, 0, 4'hF, 0);    // R2 blocked
    step(1, 3'd3, 1, 1, 0, 0, 0, 1, 6'd3, 4'hF, 2); // R10 wr load wins
    chk("R10 wr load", 32'(wrDrainCnt), 3);
    chk("R5 no strobe on drain", {31'd0, wrServed}, 0);
    step(1, 3'd3, 1, 1, 0, 0, 0, 0, 0, 4'hF, 0);    // R5 to 2
    step(1, 3'd3, 0, 1, 0, 0, 0, 0, 0, 4'hF, 2'd2); // R6 non-drain
    step(1, 3'd5, 0, 1, 0, 0, 0, 0, 0, 4'hF, 0);    // R8 invalid
    step(1, 3'd2, 1, 1, 0, 0, 0, 1, 6'd0, 4'hF, 0); // clear, R4 drain read outside wb
    step(1, 3'd2, 1, 1, 0, 0, 0, 0, 0, 4'hF, 0);
    chk("R4 no change outside wb", 32'(rdDrainCnt), 0);
    // R7 re-entry restarts stats
    step(1, 3'd3, 0, 1, 1, 0, 0, 0, 0, 4'hF, 1);
    chk("R7 restart", 32'(wbWrIssues), 1);
    chk("R7 restart rd", 32'(wbRdIssues), 0);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] t;
      logic wbR;
      t = ($urandom % 12 == 0) ? 3'(4 + $urandom % 4) : 3'($urandom % 4);
      wbR = ((i / 40) % 2) == 1;
      step($urandom % 8 != 0, t, $urandom % 2, $urandom % 4 != 0, wbR,
           $urandom % 20 == 0, CNT_W'($urandom % 4),
           $urandom % 20 == 0, CNT_W'($urandom % 4),
           4'($urandom), CHAN_W'($urandom));
    end
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule